// File: doc/BRIEF.md
# Register Rename Unit with Physical Tag Pool

This block is the rename stage of a small out-of-order core. It tracks a pool of unused physical register tags and a map that links each architectural destination to the physical tag of its newest in-flight value. Each register write in flight gets its own physical name. Two writes to the same architectural register therefore never collide, and a later write never overwrites a value that an older reader still needs. This removes write-after-write and write-after-read hazards.

A dispatching instruction presents one destination index and two source indices on a valid/ready stream. When the transfer is accepted, the unit hands out a fresh tag and records the new link. In the same cycle it reports, for each source, whether a live link exists and which tag it names. A source with no live link reads the architectural register file. When an instruction commits, its value is copied into the architectural file. The commit port then names the architectural register and tag. The unit drops the link if that link is still current, and it always returns the tag to the pool.

Back-pressure works as follows. `disp_ready` falls only when the pool is empty and no tag is being returned in that cycle. A dispatch is taken only on a cycle where `disp_valid` and `disp_ready` are both high. The commit port has no ready signal and is always accepted. When a commit and a dispatch arrive in the same cycle, the commit is applied first.

Top module: `rename_unit`

## Requirements
- R1: After reset the pool holds all 16 tags, `disp_ready` is 1, the first tag offered is 0, and no architectural register has a live link.
- R2: Accepted dispatches receive tags in pool order (first-in first-out). Tags 0 through 15 are issued in ascending order after reset, and returned tags join the tail.
- R3: For each source, the hit output is 1 with the tag of the newest live link, or 0 when there is no live link (the operand then comes from the architectural file).
- R4: Two dispatches to the same architectural destination receive different tags, and later lookups return the newer one.
- R5: A commit clears a link only when the link still names the committing tag. A younger link to the same register stays in place.
- R6: Every commit returns its tag to the pool, and that tag is issued again after the tags already waiting.
- R7: With the pool empty and no commit, `disp_ready` is 0. A presented dispatch then changes neither the links nor the pool.
- R8: When a commit and a dispatch arrive in the same cycle, the clear happens before the new link is written. A new link to the same register survives, and that cycle's source lookups already see the cleared state.
- R9: With the pool empty, a commit in the same cycle makes `disp_ready` 1, and the dispatch receives the tag being returned.
- R10: A source equal to the instruction's own destination reports the link that existed before this dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request present |
| disp_ready | output | 1 | A tag can be granted this cycle (low means stall) |
| disp_dst | input | 3 | Destination architectural index |
| disp_src0 | input | 3 | First source architectural index |
| disp_src1 | input | 3 | Second source architectural index |
| disp_ptag | output | 4 | Tag granted to the destination |
| src0_hit | output | 1 | First source has a live link |
| src0_ptag | output | 4 | Tag linked to the first source |
| src1_hit | output | 1 | Second source has a live link |
| src1_ptag | output | 4 | Tag linked to the second source |
| cmt_valid | input | 1 | Commit release present |
| cmt_arch | input | 3 | Architectural index being committed |
| cmt_ptag | input | 4 | Physical tag being released |

## Verification
The assertions assume that commits are legal. Each commit carries a tag that is currently handed out, paired with the architectural index it was granted for, and arrives in dispatch order. Under that assumption the pool can never be pushed past 16 entries. The stimulus keeps to this rule: it commits only tags that earlier accepted dispatches received, in the order they were granted. It never releases a tag that is still waiting in the pool.

// File: rtl/rename_pkg.sv
package rename_pkg;

  localparam int unsigned ARCH_REGS_DEF = 8;
  localparam int unsigned PHYS_REGS_DEF = 16;

  // what the tag pool does in a given cycle
  typedef enum logic [2:0] {
    FL_IDLE   = 3'd0,
    FL_POP    = 3'd1,
    FL_PUSH   = 3'd2,
    FL_SWAP   = 3'd3,  // pop head and push returned tag together
    FL_BYPASS = 3'd4   // empty pool, returned tag handed straight out
  } fl_action_e;

endpackage

// File: rtl/rename_freelist.sv
module rename_freelist
  import rename_pkg::*;
#(
  parameter int unsigned DEPTH = PHYS_REGS_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         pop_req,
  input  logic                         push_en,
  input  logic [$clog2(DEPTH)-1:0]     push_tag,
  output logic                         avail,
  output logic                         pop_fire,
  output logic [$clog2(DEPTH)-1:0]     head_tag,
  output logic [$clog2(DEPTH+1)-1:0]   level
);

  localparam int unsigned TW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [TW-1:0] LAST_SLOT = TW'(DEPTH-1);

  logic [TW-1:0] slot_q [DEPTH];
  logic [TW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          empty;
  fl_action_e    act;

  function automatic logic [TW-1:0] step(input logic [TW-1:0] p);
    return (p == LAST_SLOT) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt_q == '0);
  assign avail    = !empty || push_en;
  assign pop_fire = pop_req && avail;
  assign head_tag = empty ? push_tag : slot_q[rd_q];
  assign level    = cnt_q;

  always_comb begin
    if (pop_fire && push_en)
      act = empty ? FL_BYPASS : FL_SWAP;
    else if (pop_fire)
      act = FL_POP;
    else if (push_en)
      act = FL_PUSH;
    else
      act = FL_IDLE;
  end

  // storage: full of tags 0..DEPTH-1 after reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++)
        slot_q[i] <= TW'(i);
    end else if (act == FL_PUSH || act == FL_SWAP) begin
      slot_q[wr_q] <= push_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= CW'(DEPTH);
    end else begin
      unique case (act)
        FL_POP: begin
          rd_q  <= step(rd_q);
          cnt_q <= cnt_q - 1'b1;
        end
        FL_PUSH: begin
          wr_q  <= step(wr_q);
          cnt_q <= cnt_q + 1'b1;
        end
        FL_SWAP: begin
          rd_q <= step(rd_q);
          wr_q <= step(wr_q);
        end
        FL_BYPASS, FL_IDLE: begin
        end
        default: begin
        end
      endcase
    end
  end

endmodule

// File: rtl/rename_map_table.sv
module rename_map_table
  import rename_pkg::*;
#(
  parameter int unsigned ARCH_REGS = ARCH_REGS_DEF,
  parameter int unsigned PHYS_REGS = PHYS_REGS_DEF,
  parameter int unsigned RD_PORTS  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [$clog2(ARCH_REGS)-1:0]   wr_arch,
  input  logic [$clog2(PHYS_REGS)-1:0]   wr_tag,
  input  logic                           clr_en,
  input  logic [$clog2(ARCH_REGS)-1:0]   clr_arch,
  input  logic [$clog2(PHYS_REGS)-1:0]   clr_tag,
  input  logic [$clog2(ARCH_REGS)-1:0]   rd_arch [RD_PORTS],
  output logic                           rd_hit  [RD_PORTS],
  output logic [$clog2(PHYS_REGS)-1:0]   rd_tag  [RD_PORTS]
);

  localparam int unsigned AW = $clog2(ARCH_REGS);
  localparam int unsigned TW = $clog2(PHYS_REGS);

  logic [ARCH_REGS-1:0] live_q;
  logic [TW-1:0]        link_q   [ARCH_REGS];
  logic [ARCH_REGS-1:0] kill_now;  // entry released by this cycle's commit

  for (genvar e = 0; e < int'(ARCH_REGS); e++) begin : g_entry
    logic sel_wr, sel_clr;
    assign sel_wr      = wr_en  && (wr_arch  == AW'(e));
    assign sel_clr     = clr_en && (clr_arch == AW'(e));
    assign kill_now[e] = sel_clr && live_q[e] && (link_q[e] == clr_tag);

    // commit clears first, a same-cycle dispatch write then wins
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        live_q[e] <= 1'b0;
        link_q[e] <= '0;
      end else if (sel_wr) begin
        live_q[e] <= 1'b1;
        link_q[e] <= wr_tag;
      end else if (kill_now[e]) begin
        live_q[e] <= 1'b0;
      end
    end
  end

  // lookups see the table after this cycle's commit, before the new link
  for (genvar r = 0; r < int'(RD_PORTS); r++) begin : g_read
    assign rd_hit[r] = live_q[rd_arch[r]] && !kill_now[rd_arch[r]];
    assign rd_tag[r] = link_q[rd_arch[r]];
  end

endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
#(
  parameter int unsigned ARCH_REGS = ARCH_REGS_DEF,
  parameter int unsigned PHYS_REGS = PHYS_REGS_DEF
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         disp_valid,
  output logic                         disp_ready,
  input  logic [$clog2(ARCH_REGS)-1:0] disp_dst,
  input  logic [$clog2(ARCH_REGS)-1:0] disp_src0,
  input  logic [$clog2(ARCH_REGS)-1:0] disp_src1,
  output logic [$clog2(PHYS_REGS)-1:0] disp_ptag,
  output logic                         src0_hit,
  output logic [$clog2(PHYS_REGS)-1:0] src0_ptag,
  output logic                         src1_hit,
  output logic [$clog2(PHYS_REGS)-1:0] src1_ptag,
  input  logic                         cmt_valid,
  input  logic [$clog2(ARCH_REGS)-1:0] cmt_arch,
  input  logic [$clog2(PHYS_REGS)-1:0] cmt_ptag
);

  localparam int unsigned AW = $clog2(ARCH_REGS);
  localparam int unsigned TW = $clog2(PHYS_REGS);
  localparam int unsigned CW = $clog2(PHYS_REGS+1);
  localparam int unsigned NSRC = 2;

  logic          grant;
  logic [CW-1:0] fl_count;
  logic [AW-1:0] look_arch [NSRC];
  logic          look_hit  [NSRC];
  logic [TW-1:0] look_tag  [NSRC];

  rename_freelist #(.DEPTH(PHYS_REGS)) u_pool (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop_req  (disp_valid),
    .push_en  (cmt_valid),
    .push_tag (cmt_ptag),
    .avail    (disp_ready),
    .pop_fire (grant),
    .head_tag (disp_ptag),
    .level    (fl_count)
  );

  assign look_arch[0] = disp_src0;
  assign look_arch[1] = disp_src1;

  rename_map_table #(
    .ARCH_REGS (ARCH_REGS),
    .PHYS_REGS (PHYS_REGS),
    .RD_PORTS  (NSRC)
  ) u_map (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (grant),
    .wr_arch  (disp_dst),
    .wr_tag   (disp_ptag),
    .clr_en   (cmt_valid),
    .clr_arch (cmt_arch),
    .clr_tag  (cmt_ptag),
    .rd_arch  (look_arch),
    .rd_hit   (look_hit),
    .rd_tag   (look_tag)
  );

  assign src0_hit  = look_hit[0];
  assign src0_ptag = look_tag[0];
  assign src1_hit  = look_hit[1];
  assign src1_ptag = look_tag[1];

endmodule

// File: rtl/rename_unit_checker.sv
module rename_unit_checker #(
  parameter int unsigned PHYS_REGS = 16
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           disp_valid,
  input logic                           disp_ready,
  input logic [$clog2(PHYS_REGS)-1:0]   disp_ptag,
  input logic                           cmt_valid,
  input logic [$clog2(PHYS_REGS)-1:0]   cmt_ptag,
  input logic [$clog2(PHYS_REGS+1)-1:0] fl_count
);

  localparam int unsigned CW = $clog2(PHYS_REGS+1);

  // R7: empty pool with nothing returned must stall
  p_stall_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_count == '0 && !cmt_valid) |-> !disp_ready);

  // R7: a refused dispatch leaves the pool untouched
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !disp_ready) |=> (fl_count == $past(fl_count)));

  // R2: an accepted dispatch alone consumes exactly one tag
  p_pop_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && disp_ready && !cmt_valid) |=> (fl_count == $past(fl_count) - 1'b1));

  // R6: a commit alone adds exactly one tag
  p_push_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmt_valid && !disp_valid) |=> (fl_count == $past(fl_count) + 1'b1));

  // R6: a legal commit never meets a full pool
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid |-> (fl_count < CW'(PHYS_REGS)));

  // R9: empty pool plus commit forwards the returned tag
  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_count == '0 && cmt_valid && disp_valid) |-> (disp_ready && disp_ptag == cmt_ptag));

endmodule

bind rename_unit rename_unit_checker #(.PHYS_REGS(PHYS_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_valid (disp_valid),
  .disp_ready (disp_ready),
  .disp_ptag  (disp_ptag),
  .cmt_valid  (cmt_valid),
  .cmt_ptag   (cmt_ptag),
  .fl_count   (fl_count)
);

// File: tb/rename_unit_test.sv
`timescale 1ns/1ps
module rename_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       disp_valid = 1'b0;
  logic       disp_ready;
  logic [2:0] disp_dst = '0, disp_src0 = '0, disp_src1 = '0;
  logic [3:0] disp_ptag;
  logic       src0_hit, src1_hit;
  logic [3:0] src0_ptag, src1_ptag;
  logic       cmt_valid = 1'b0;
  logic [2:0] cmt_arch = '0;
  logic [3:0] cmt_ptag = '0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rename_unit uut (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_dst(disp_dst), .disp_src0(disp_src0), .disp_src1(disp_src1),
    .disp_ptag(disp_ptag),
    .src0_hit(src0_hit), .src0_ptag(src0_ptag),
    .src1_hit(src1_hit), .src1_ptag(src1_ptag),
    .cmt_valid(cmt_valid), .cmt_arch(cmt_arch), .cmt_ptag(cmt_ptag)
  );

  typedef struct packed {
    logic       dv;
    logic [2:0] dst, s0, s1;
    logic       cv;
    logic [2:0] carch;
    logic [3:0] ctag;
    logic       e_rdy;
    logic [3:0] e_ptag;
    logic       e_h0;
    logic [3:0] e_t0;
    logic       e_h1;
    logic [3:0] e_t1;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 3'd1, 3'd1, 3'd2, 1'b0, 3'd0, 4'd0,  1'b1, 4'd0, 1'b0, 4'd0, 1'b0, 4'd0},
    '{1'b1, 3'd2, 3'd1, 3'd2, 1'b0, 3'd0, 4'd0,  1'b1, 4'd1, 1'b1, 4'd0, 1'b0, 4'd0},
    '{1'b1, 3'd1, 3'd1, 3'd2, 1'b0, 3'd0, 4'd0,  1'b1, 4'd2, 1'b1, 4'd0, 1'b1, 4'd1},
    '{1'b0, 3'd0, 3'd1, 3'd2, 1'b0, 3'd0, 4'd0,  1'b1, 4'd3, 1'b1, 4'd2, 1'b1, 4'd1},
    '{1'b0, 3'd0, 3'd1, 3'd2, 1'b1, 3'd1, 4'd0,  1'b1, 4'd3, 1'b1, 4'd2, 1'b1, 4'd1},
    '{1'b0, 3'd0, 3'd1, 3'd2, 1'b0, 3'd0, 4'd0,  1'b1, 4'd3, 1'b1, 4'd2, 1'b1, 4'd1},
    '{1'b1, 3'd2, 3'd2, 3'd1, 1'b1, 3'd2, 4'd1,  1'b1, 4'd3, 1'b0, 4'd0, 1'b1, 4'd2},
    '{1'b0, 3'd0, 3'd2, 3'd1, 1'b0, 3'd0, 4'd0,  1'b1, 4'd4, 1'b1, 4'd3, 1'b1, 4'd2},
    '{1'b0, 3'd0, 3'd1, 3'd2, 1'b1, 3'd1, 4'd2,  1'b1, 4'd4, 1'b0, 4'd0, 1'b1, 4'd3},
    '{1'b0, 3'd0, 3'd1, 3'd2, 1'b0, 3'd0, 4'd0,  1'b1, 4'd4, 1'b0, 4'd0, 1'b1, 4'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic dv, input logic [2:0] dst, input logic [2:0] s0,
                       input logic [2:0] s1, input logic cv, input logic [2:0] ca,
                       input logic [3:0] ct);
    disp_valid = dv; disp_dst = dst; disp_src0 = s0; disp_src1 = s1;
    cmt_valid = cv; cmt_arch = ca; cmt_ptag = ct;
  endtask

  task automatic idle_inputs();
    drive(1'b0, 3'd0, 3'd0, 3'd0, 1'b0, 3'd0, 4'd0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic check_reset_state();
    #1;
    check(disp_ready == 1'b1, "R1 ready after reset", int'(disp_ready), 1);
    check(disp_ptag == 4'd0, "R1 first tag", int'(disp_ptag), 0);
    for (int a = 0; a < 8; a++) begin
      disp_src0 = 3'(a);
      #0.2;
      check(src0_hit == 1'b0, "R1 no live link after reset", int'(src0_hit), 0);
    end
    disp_src0 = 3'd0;
  endtask

  string vreq [NV] = '{"R1 R10", "R2 R3", "R4 R10", "R4", "R5", "R5", "R8", "R8", "R3 R6", "R5"};

  initial begin
    #(20000 * 5);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    check_reset_state();

    // table walk from reset: drive at negedge, sample 1 ns later, then clock
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i].dv, VEC[i].dst, VEC[i].s0, VEC[i].s1, VEC[i].cv, VEC[i].carch, VEC[i].ctag);
      #1;
      check(disp_ready == VEC[i].e_rdy, vreq[i], int'(disp_ready), int'(VEC[i].e_rdy));
      if (VEC[i].dv)
        check(disp_ptag == VEC[i].e_ptag, vreq[i], int'(disp_ptag), int'(VEC[i].e_ptag));
      check(src0_hit == VEC[i].e_h0, vreq[i], int'(src0_hit), int'(VEC[i].e_h0));
      if (VEC[i].e_h0)
        check(src0_ptag == VEC[i].e_t0, vreq[i], int'(src0_ptag), int'(VEC[i].e_t0));
      check(src1_hit == VEC[i].e_h1, vreq[i], int'(src1_hit), int'(VEC[i].e_h1));
      if (VEC[i].e_h1)
        check(src1_ptag == VEC[i].e_t1, vreq[i], int'(src1_ptag), int'(VEC[i].e_t1));
    end

    // drain: 15 tags remain, 4..15 then returned 0,1,2 (R2, R6)
    for (int k = 0; k < 15; k++) begin
      @(negedge clk);
      drive(1'b1, 3'd3, 3'd3, 3'd0, 1'b0, 3'd0, 4'd0);
      #1;
      check(disp_ready == 1'b1, "R2 ready while draining", int'(disp_ready), 1);
      check(disp_ptag == 4'((k + 4) % 16), "R6 pool order", int'(disp_ptag), (k + 4) % 16);
      if (k > 0)
        check(src0_hit && src0_ptag == 4'((k + 3) % 16), "R4 newest link", int'(src0_ptag), (k + 3) % 16);
    end

    // empty pool, no commit: stall and no effect (R7)
    @(negedge clk);
    drive(1'b1, 3'd4, 3'd4, 3'd3, 1'b0, 3'd0, 4'd0);
    #1;
    check(disp_ready == 1'b0, "R7 stall when empty", int'(disp_ready), 0);
    @(negedge clk);
    drive(1'b0, 3'd0, 3'd4, 3'd3, 1'b0, 3'd0, 4'd0);
    #1;
    check(src0_hit == 1'b0, "R7 refused dispatch wrote no link", int'(src0_hit), 0);
    check(src1_hit && src1_ptag == 4'd2, "R7 existing link unchanged", int'(src1_ptag), 2);
    check(disp_ready == 1'b0, "R7 pool still empty", int'(disp_ready), 0);

    // empty pool with commit: returned tag forwarded (R9, R8 in-cycle clear)
    @(negedge clk);
    drive(1'b1, 3'd5, 3'd2, 3'd5, 1'b1, 3'd2, 4'd3);
    #1;
    check(disp_ready == 1'b1, "R9 ready via returned tag", int'(disp_ready), 1);
    check(disp_ptag == 4'd3, "R9 forwarded tag", int'(disp_ptag), 3);
    check(src0_hit == 1'b0, "R8 lookup sees clear", int'(src0_hit), 0);
    @(negedge clk);
    drive(1'b0, 3'd0, 3'd5, 3'd2, 1'b0, 3'd0, 4'd0);
    #1;
    check(src0_hit && src0_ptag == 4'd3, "R9 link to forwarded tag", int'(src0_ptag), 3);
    check(src1_hit == 1'b0, "R5 matching link cleared", int'(src1_hit), 0);
    check(disp_ready == 1'b0, "R9 forwarding left pool empty", int'(disp_ready), 0);

    // reset again from a busy state (R1)
    do_reset();
    check_reset_state();

    idle_inputs();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule